// File: doc/BRIEF.md
# Multiply-Divide Unit with Stack Result

This block performs the two long arithmetic operations of a small accumulator-based processor. One is an 8-by-8 unsigned multiply. The other is a 16-by-8 unsigned divide. The accumulator value, a zero-page base byte, the X index and the stack pointer are sampled in the cycle that `start` is accepted. The block fetches its memory operand bytes from zero page through a synchronous byte port at base plus X. A single shared shift register then runs one shift-add or shift-subtract step per cycle.

One part of each result returns to the accumulator. The other part is written to the stack page at the current stack pointer, and the decremented stack pointer is handed back. A multiply leaves the product low byte in the accumulator and pushes the high byte. A divide leaves the quotient in the accumulator and pushes the bitwise inverse of the remainder. The latency of each operation is fixed, so the surrounding sequencer can count on a known cycle of completion.

Top module: `mdu_unit`

## Requirements
- R1: After reset, and while reset is held, `busy`, `done`, `mem_rd`, `mem_wr`, `acc_we`, `sp_we` and `div_err` are all 0.
- R2: A high `start` while `busy` is low launches an operation, with `op_div`=0 selecting multiply and 1 selecting divide. All operand inputs are sampled on that edge only. A `start` seen while `busy` is high, including the done cycle, has no effect.
- R3: Operand reads go to page 0 (`mem_addr[15:8]`=0), and data returns on `mem_rdata` one cycle after `mem_rd`. The first read is in the cycle after launch, at offset (base + X) mod 256. A divide makes a second read in the next cycle, at offset (base + X + 1) mod 256.
- R4: A multiply produces the 16-bit product of the accumulator and the byte at base + X. `acc_out` carries the low byte and `mem_wdata` carries the high byte.
- R5: A divide takes the dividend {byte at base+X+1, byte at base+X} and the divisor from the accumulator. `acc_out` carries the quotient and `mem_wdata` carries the bitwise inverse of the remainder.
- R6: The push goes to address {STACK_PAGE, SP}, which is 0x01SS by default. `sp_out` equals (SP - 1) mod 256, and `sp_we` is high in the same cycle as `mem_wr`.
- R7: `busy` stays high for exactly 15 cycles for a multiply and 16 cycles for a divide. `done`, `acc_we`, `sp_we` and `mem_wr` are high together only in the last of those cycles, and `busy` is low in the cycle after.
- R8: A divide with a zero divisor, or with a dividend high byte greater than or equal to the divisor, returns 0xFF in `acc_out`, pushes 0xFF and raises `div_err` with `done`. In every other case, and in every multiply, `div_err` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to launch an operation |
| op_div | input | 1 | 0 = multiply, 1 = divide |
| zp_base | input | 8 | Zero-page base offset of the operand |
| x_idx | input | 8 | Index added to the base |
| acc_in | input | 8 | Accumulator value (multiplier or divisor) |
| sp_in | input | 8 | Stack pointer before the push |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| mem_addr | output | 16 | Byte address for read or write |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write strobe for the push |
| mem_wdata | output | 8 | Pushed byte |
| acc_out | output | 8 | Accumulator result, valid with `acc_we` |
| acc_we | output | 1 | Accumulator write enable |
| sp_out | output | 8 | Decremented stack pointer |
| sp_we | output | 1 | Stack pointer write enable |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last cycle of an operation |
| div_err | output | 1 | Divide overflow or divide by zero, with `done` |

## Verification
The assertions assume that the memory answers every read with the addressed byte exactly one cycle later. They also assume that the operand bytes in zero page do not change between launch and their fetch, and that the stack page is distinct from page 0, so the push can never disturb an operand. The bench keeps to these assumptions with a memory model split into a zero-page array and a stack array. The zero-page array is written only by the stimulus, and only while no operation is in flight. The stack array is written only by the block's push. Between launches the stimulus changes every operand input and holds `start` high across busy windows, which exercises the sampling and ignore rules of R2.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } mdu_op_e;
endpackage

// File: rtl/mdu_seq.sv
module mdu_seq
  import mdu_pkg::*;
#(
  parameter int DW         = 8,
  parameter int MUL_CYCLES = 15,
  parameter int DIV_CYCLES = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    op_div,
  output mdu_op_e op,
  output logic    busy,
  output logic    launch,
  output logic    rd_first,
  output logic    rd_second,
  output logic    cap_first,
  output logic    cap_second,
  output logic    step,
  output logic    last
);
  localparam int MAXC = (MUL_CYCLES > DIV_CYCLES) ? MUL_CYCLES : DIV_CYCLES;
  localparam int CW   = $clog2(MAXC + DW + 4);
  localparam logic [CW-1:0] MUL_LAST  = CW'(MUL_CYCLES - 1);
  localparam logic [CW-1:0] DIV_LAST  = CW'(DIV_CYCLES - 1);
  localparam logic [CW-1:0] MUL_STEP0 = CW'(2);
  localparam logic [CW-1:0] DIV_STEP0 = CW'(3);
  localparam logic [CW-1:0] NSTEPS    = CW'(DW);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  mdu_op_e       op_q, op_d;
  logic [CW-1:0] last_idx, step0;
  logic          cnt_en;

  always_comb begin
    last_idx = (op_q == OP_DIV) ? DIV_LAST : MUL_LAST;
    step0    = (op_q == OP_DIV) ? DIV_STEP0 : MUL_STEP0;
    launch   = start && !busy_q;
    last     = busy_q && (cnt_q == last_idx);
    cnt_en   = launch || busy_q;
    busy_d   = busy_q;
    cnt_d    = cnt_q;
    op_d     = op_q;
    if (launch) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      op_d   = op_div ? OP_DIV : OP_MUL;
    end else if (last) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_MUL;
    end else if (cnt_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      op_q   <= op_d;
    end
  end

  always_comb begin
    rd_first   = busy_q && (cnt_q == '0);
    rd_second  = busy_q && (op_q == OP_DIV) && (cnt_q == CW'(1));
    cap_first  = busy_q && (cnt_q == CW'(1));
    cap_second = busy_q && (op_q == OP_DIV) && (cnt_q == CW'(2));
    step       = busy_q && (cnt_q >= step0) && (cnt_q < step0 + NSTEPS);
  end

  assign op   = op_q;
  assign busy = busy_q;

  // Independent age counter, used only by the latency checks below.
  logic [CW-1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (launch) begin
      age_q <= '0;
    end else if (busy_q && (age_q != '1)) begin
      age_q <= age_q + 1'b1;
    end
  end

  // R7
  mul_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && op_q == OP_MUL) |-> (age_q == MUL_LAST));
  // R7
  div_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && op_q == OP_DIV) |-> (age_q == DIV_LAST));
  // R7
  done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy_q);
  // R2
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> $stable(op_q));
endmodule

// File: rtl/mdu_core.sv
module mdu_core
  import mdu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mdu_op_e       op,
  input  logic          launch,
  input  logic          cap_first,
  input  logic          cap_second,
  input  logic          step,
  input  logic [DW-1:0] acc_in,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] res_acc,
  output logic [DW-1:0] res_push,
  output logic          err
);
  // hi/lo form one 2*DW shift register shared by both operations:
  // multiply: {partial high, multiplier shifting out / product low shifting in}
  // divide:   {partial remainder, dividend low shifting out / quotient shifting in}
  logic [DW-1:0] hi_q, hi_d, lo_q, lo_d, opd_q, opd_d;
  logic          err_q, err_d;
  logic [DW:0]   sum, trial;
  logic          ge;
  logic          reg_en;

  always_comb begin
    sum    = {1'b0, hi_q} + (lo_q[0] ? {1'b0, opd_q} : '0);
    trial  = {hi_q, lo_q[DW-1]};
    ge     = trial >= {1'b0, opd_q};
    reg_en = launch || cap_first || cap_second || step;
    hi_d   = hi_q;
    lo_d   = lo_q;
    opd_d  = opd_q;
    err_d  = err_q;
    if (launch) begin
      hi_d  = '0;
      lo_d  = acc_in;
      opd_d = acc_in;
      err_d = 1'b0;
    end else if (cap_first) begin
      if (op == OP_MUL) opd_d = rdata;
      else              lo_d  = rdata;
    end else if (cap_second) begin
      hi_d  = rdata;
      err_d = (opd_q == '0) || (rdata >= opd_q);
    end else if (step) begin
      if (op == OP_MUL) begin
        {hi_d, lo_d} = {sum, lo_q[DW-1:1]};
      end else if (!err_q) begin
        hi_d = ge ? DW'(trial - {1'b0, opd_q}) : DW'(trial);
        lo_d = {lo_q[DW-2:0], ge};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      opd_q <= '0;
      err_q <= 1'b0;
    end else if (reg_en) begin
      hi_q  <= hi_d;
      lo_q  <= lo_d;
      opd_q <= opd_d;
      err_q <= err_d;
    end
  end

  always_comb begin
    err      = (op == OP_DIV) && err_q;
    res_acc  = err ? '1 : lo_q;
    res_push = (op == OP_DIV) ? (err_q ? '1 : ~hi_q) : hi_q;
  end

  // R5
  div_rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DIV && step && !err_q) |-> (hi_q < opd_q));
endmodule

// File: rtl/mdu_bus.sv
module mdu_bus #(
  parameter int DW         = 8,
  parameter int STACK_PAGE = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  logic            rd_first,
  input  logic            rd_second,
  input  logic            last,
  input  logic [DW-1:0]   zp_base,
  input  logic [DW-1:0]   x_idx,
  input  logic [DW-1:0]   sp_in,
  input  logic [DW-1:0]   push_data,
  output logic [2*DW-1:0] mem_addr,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [DW-1:0]   mem_wdata,
  output logic [DW-1:0]   sp_out,
  output logic            sp_we
);
  localparam logic [DW-1:0] SPAGE = DW'(STACK_PAGE);
  localparam logic [DW-1:0] ZPAGE = '0;

  logic [DW-1:0] ea_q, ea_d, sp_q, sp_d, ea_next;

  always_comb begin
    ea_d = ea_q;
    sp_d = sp_q;
    if (launch) begin
      ea_d = zp_base + x_idx;  // wraps inside the zero page
      sp_d = sp_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q <= '0;
      sp_q <= '0;
    end else if (launch) begin
      ea_q <= ea_d;
      sp_q <= sp_d;
    end
  end

  always_comb begin
    ea_next   = ea_q + 1'b1;
    mem_rd    = rd_first || rd_second;
    mem_wr    = last;
    sp_we     = last;
    sp_out    = sp_q - 1'b1;
    mem_wdata = push_data;
    if (rd_first)       mem_addr = {ZPAGE, ea_q};
    else if (rd_second) mem_addr = {ZPAGE, ea_next};
    else if (last)      mem_addr = {SPAGE, sp_q};
    else                mem_addr = '0;
  end

  // R3
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R3
  read_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr[2*DW-1:DW] == ZPAGE));
  // R6
  push_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_addr[2*DW-1:DW] == SPAGE && sp_we));
endmodule

// File: rtl/mdu_unit.sv
module mdu_unit
  import mdu_pkg::*;
#(
  parameter int DW         = 8,
  parameter int MUL_CYCLES = 15,
  parameter int DIV_CYCLES = 16,
  parameter int STACK_PAGE = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            op_div,
  input  logic [DW-1:0]   zp_base,
  input  logic [DW-1:0]   x_idx,
  input  logic [DW-1:0]   acc_in,
  input  logic [DW-1:0]   sp_in,
  input  logic [DW-1:0]   mem_rdata,
  output logic [2*DW-1:0] mem_addr,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [DW-1:0]   mem_wdata,
  output logic [DW-1:0]   acc_out,
  output logic            acc_we,
  output logic [DW-1:0]   sp_out,
  output logic            sp_we,
  output logic            busy,
  output logic            done,
  output logic            div_err
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  mdu_op_e       op;
  logic          launch, rd_first, rd_second, cap_first, cap_second, step, last;
  logic [DW-1:0] res_acc, res_push;
  logic          err;

  mdu_seq #(
    .DW(DW), .MUL_CYCLES(MUL_CYCLES), .DIV_CYCLES(DIV_CYCLES)
  ) i_seq (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .op_div(op_div),
    .op(op), .busy(busy), .launch(launch), .rd_first(rd_first),
    .rd_second(rd_second), .cap_first(cap_first), .cap_second(cap_second),
    .step(step), .last(last)
  );

  mdu_core #(.DW(DW)) i_core (
    .clk(clk), .rst_n(rst_sync_n), .op(op), .launch(launch),
    .cap_first(cap_first), .cap_second(cap_second), .step(step),
    .acc_in(acc_in), .rdata(mem_rdata), .res_acc(res_acc),
    .res_push(res_push), .err(err)
  );

  mdu_bus #(.DW(DW), .STACK_PAGE(STACK_PAGE)) i_bus (
    .clk(clk), .rst_n(rst_sync_n), .launch(launch), .rd_first(rd_first),
    .rd_second(rd_second), .last(last), .zp_base(zp_base), .x_idx(x_idx),
    .sp_in(sp_in), .push_data(res_push), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .sp_out(sp_out), .sp_we(sp_we)
  );

  assign done    = last;
  assign acc_we  = last;
  assign acc_out = res_acc;
  assign div_err = last && err;

  // R2
  launch_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start && !busy) |=> busy);
  // R8
  err_sat_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    div_err |-> (done && acc_out == '1 && mem_wdata == '1));
  // R8
  mul_no_err_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && op == OP_MUL) |-> !div_err);
  // R7
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> (busy && acc_we && sp_we && mem_wr));
endmodule

// File: tb/test_mdu_unit.sv
module test_mdu_unit;
  localparam int CLK_PERIOD = 10;
  localparam int MUL_LAT    = 15;
  localparam int DIV_LAT    = 16;
  localparam int WDOG       = 20000;

  logic        clk = 1'b0;
  logic        rst_n, start, op_div;
  logic [7:0]  zp_base, x_idx, acc_in, sp_in, mem_rdata;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, acc_we, sp_we, busy, done, div_err;
  logic [7:0]  mem_wdata, acc_out, sp_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdu_unit i_mdu_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
    .zp_base(zp_base), .x_idx(x_idx), .acc_in(acc_in), .sp_in(sp_in),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .acc_out(acc_out),
    .acc_we(acc_we), .sp_out(sp_out), .sp_we(sp_we), .busy(busy),
    .done(done), .div_err(div_err)
  );

  // Memory model: zero page written by stimulus only, stack page by the push only.
  logic [7:0] zp  [0:255];
  logic [7:0] stk [0:255];
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem_addr[8] ? stk[mem_addr[7:0]] : zp[mem_addr[7:0]];
    if (mem_wr && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
  end

  int checks = 0, fails = 0, cyc = 0;
  bit fin = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    fin = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Behavioural reference model, advanced on every rising edge.
  int m_busy = 0, m_cnt = 0, m_len = 0, m_op = 0, m_acc = 0, m_push = 0;
  int m_err = 0, m_sp = 0, m_ea = 0, m_launches = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0;
      m_cnt  = 0;
    end else if (m_busy != 0) begin
      if (m_cnt == m_len - 1) m_busy = 0;
      else m_cnt++;
    end else if (start) begin
      int a, p, dvd;
      a = int'(acc_in);
      m_op = int'(op_div);
      m_sp = int'(sp_in);
      m_ea = (int'(zp_base) + int'(x_idx)) % 256;
      if (m_op == 0) begin
        p = int'(zp[m_ea]) * a;
        m_acc = p % 256; m_push = p / 256; m_err = 0; m_len = MUL_LAT;
      end else begin
        dvd = int'(zp[(m_ea + 1) % 256]) * 256 + int'(zp[m_ea]);
        if (a == 0 || dvd / 256 >= a) begin
          m_acc = 255; m_push = 255; m_err = 1;
        end else begin
          m_acc = dvd / a; m_push = 255 - (dvd % a); m_err = 0;
        end
        m_len = DIV_LAT;
      end
      m_busy = 1;
      m_cnt  = 0;
      m_launches++;
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      bit e_done, e_rd;
      int e_addr;
      string rt;
      e_done = (m_busy != 0) && (m_cnt == m_len - 1);
      e_rd   = (m_busy != 0) && (m_cnt == 0 || (m_op == 1 && m_cnt == 1));
      e_addr = (m_cnt == 0) ? m_ea : (m_ea + 1) % 256;
      rt     = (m_op == 1) ? "R5" : "R4";
      chk(int'(busy) == m_busy, "R7 busy", busy, m_busy);
      chk(done == e_done, "R7 done", done, e_done);
      chk(mem_rd == e_rd, "R3 read strobe", mem_rd, e_rd);
      if (e_rd) chk(int'(mem_addr) == e_addr, "R3 read address", mem_addr, e_addr);
      if (e_done) begin
        chk(acc_we && sp_we && mem_wr, "R7 write strobes", {acc_we, sp_we, mem_wr}, 3'b111);
        chk(int'(mem_addr) == 256 + m_sp, "R6 push address", mem_addr, 256 + m_sp);
        chk(int'(sp_out) == (m_sp + 255) % 256, "R6 sp_out", sp_out, (m_sp + 255) % 256);
        chk(int'(acc_out) == m_acc, {rt, " acc result"}, acc_out, m_acc);
        chk(int'(mem_wdata) == m_push, {rt, " pushed byte"}, mem_wdata, m_push);
        chk(int'(div_err) == m_err, "R8 div_err", div_err, m_err);
      end else begin
        chk(!(acc_we || sp_we || mem_wr), "R7 idle strobes", {acc_we, sp_we, mem_wr}, 0);
        chk(!div_err, "R8 div_err outside done", div_err, 0);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WDOG && !fin) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WDOG);
      report();
    end
  end

  task automatic idle_check(input string tag);
    chk(!(busy || done || mem_rd || mem_wr || acc_we || sp_we || div_err),
        {"R1 ", tag},
        {busy, done, mem_rd, mem_wr, acc_we, sp_we, div_err}, 0);
  endtask

  task automatic set_in(input bit d, input logic [7:0] zz, x, a, sp);
    op_div = d; zp_base = zz; x_idx = x; acc_in = a; sp_in = sp;
  endtask

  task automatic scramble();
    op_div = ~op_div; zp_base = ~zp_base; x_idx = x_idx + 8'd3;
    acc_in = ~acc_in; sp_in = sp_in ^ 8'h5A;
  endtask

  task automatic run_op(input bit d, input logic [7:0] zz, x, a, sp);
    @(negedge clk);
    set_in(d, zz, x, a, sp);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    scramble();  // R2: inputs after launch must not matter
    while (m_busy != 0) @(negedge clk);
  endtask

  initial begin
    int n0;
    rst_n = 1'b0; start = 1'b0;
    set_in(1'b0, 8'h00, 8'h00, 8'h00, 8'h00);
    for (int i = 0; i < 256; i++) begin
      zp[i]  = 8'((i * 37 + 11) % 256);
      stk[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    idle_check("held in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_check("after reset");

    // R4: ordinary product, product with full high byte, zero multiplicand
    zp[8'h25] = 8'd13;  run_op(1'b0, 8'h20, 8'h05, 8'd11, 8'hFF);
    zp[8'h40] = 8'hFF;  run_op(1'b0, 8'h40, 8'h00, 8'hFF, 8'h80);
    zp[8'h41] = 8'h00;  run_op(1'b0, 8'h31, 8'h10, 8'h9C, 8'h10);
    // R3: base + X wraps within the zero page
    zp[8'h10] = 8'h3C;  run_op(1'b0, 8'hF0, 8'h20, 8'h07, 8'h44);
    // R5: 1000 / 7
    zp[8'h90] = 8'hE8; zp[8'h91] = 8'h03; run_op(1'b1, 8'h80, 8'h10, 8'd7, 8'hC0);
    // R3 R5: high byte address wraps to 0x00, largest non-overflow quotient
    zp[8'hFF] = 8'hFF; zp[8'h00] = 8'h04; run_op(1'b1, 8'hFF, 8'h00, 8'd5, 8'h22);
    // R5: zero remainder pushes 0xFF without error; divisor 0xFF
    zp[8'h50] = 8'h01; zp[8'h51] = 8'h00; run_op(1'b1, 8'h50, 8'h00, 8'd1, 8'h33);
    zp[8'h60] = 8'hFF; zp[8'h61] = 8'hFE; run_op(1'b1, 8'h60, 8'h00, 8'hFF, 8'h34);
    // R8: divide by zero, and high byte equal to divisor
    run_op(1'b1, 8'h60, 8'h00, 8'h00, 8'h35);
    zp[8'h70] = 8'h00; zp[8'h71] = 8'h05; run_op(1'b1, 8'h70, 8'h00, 8'd5, 8'h36);
    // R6: stack pointer 0x00 pushes to 0x0100 and wraps to 0xFF
    run_op(1'b0, 8'h20, 8'h05, 8'd200, 8'h00);
    chk(stk[8'h00] == 8'h0A, "R6 stack byte stored", stk[8'h00], 8'h0A);

    // R2: start held high through a divide; a multiply follows the cycle after done
    @(negedge clk);
    zp[8'hA0] = 8'h34; zp[8'hA1] = 8'h12;
    set_in(1'b1, 8'hA0, 8'h00, 8'h40, 8'h90);
    start = 1'b1;
    n0 = m_launches;
    @(negedge clk);
    set_in(1'b0, 8'h25, 8'h00, 8'd3, 8'h91);
    while (m_launches < n0 + 2) @(negedge clk);
    start = 1'b0;
    scramble();
    while (m_busy != 0) @(negedge clk);

    // R1: reset in the middle of an operation returns to idle
    @(negedge clk);
    set_in(1'b1, 8'h80, 8'h10, 8'd7, 8'h50);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    idle_check("reset during operation");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_check("after mid-operation reset");
    run_op(1'b1, 8'h80, 8'h10, 8'd9, 8'h51);

    repeat (2) @(negedge clk);
    report();
  end
endmodule